// File: doc/BRIEF.md
# Dual-Parity Store Checker With Retry

This block stands between a requester and a word-wide store memory and guards every access with parity. A write first has its incoming byte parity checked. If that check passes, the word goes to memory with two extra bits: one even parity bit over the address alone and one over the address and data together. A write whose byte parity is wrong never reaches the memory. It is answered with an error and is not retried.

On a read, the block recomputes both parity bits from the latched address and the returned data and compares them with the stored bits. A mismatch causes the read to be issued again in hardware, up to a parameterised number of times. A read that comes back clean after one or more retries is answered normally and counted as a soft error. A read that stays bad raises a sticky hard-error flag and captures the failing address. The failure is classed as an addressing fault when the address-only bit disagrees, and as a data fault when only the combined bit disagrees.

The requester holds its request until the one-cycle ready pulse, which arrives only after a clean check, a write, a rejected write or a hard error. The memory is a synchronous RAM with one cycle of read latency, outside the block.

Top module: `dpsc_top`

## Requirements
- R1: A write with good byte parity performs exactly one memory write. The stored word is {addrPar, fullPar, data}: bit DW+1 holds addrPar, bit DW holds fullPar and bits DW-1:0 hold the data. A clean read returns that data with all response flags low.
- R2: All parity is even. addrPar is the XOR of the address bits. fullPar is the XOR of the address and data bits. Byte i of the write data is valid when the XOR of data bits 8i+7:8i and reqBytePar[i] is 0.
- R3: A write with any byte parity error makes no memory access of any kind, answers with rspWrParErr high and is not retried.
- R4: On a read whose final check fails and whose stored addrPar disagrees with the recomputed address parity, rspAddrFault is high and rspDataFault is low.
- R5: On a read whose final check fails with addrPar correct and fullPar wrong, rspDataFault is high and rspAddrFault is low.
- R6: A failing read is re-issued up to MAX_RETRY (default 3) more times, giving MAX_RETRY+1 reads in all. If every read fails, the response has rspHardErr high, the sticky hardErr output goes high and hardAddr holds the request address.
- R7: A read that fails at least once and then checks clean returns the correct data with all flags low, and increments softCount by one. A read that is clean on its first attempt leaves softCount unchanged.
- R8: reqReady is a single-cycle pulse. It comes one cycle after a write or rejected write is accepted, and n+1 cycles after a read is accepted, where n is the number of memory reads made.
- R9: After reset, reqReady, memEn, hardErr and all response flags are low and softCount is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Request address |
| reqData | input | DW | Write data |
| reqBytePar | input | DW/8 | Even parity bit per write-data byte |
| reqReady | output | 1 | One-cycle completion pulse |
| rspData | output | DW | Read data, valid with reqReady |
| rspWrParErr | output | 1 | Write rejected for byte parity |
| rspAddrFault | output | 1 | Hard read error classed as addressing fault |
| rspDataFault | output | 1 | Hard read error classed as data fault |
| rspHardErr | output | 1 | Read failed after all retries |
| hardErr | output | 1 | Sticky hard-error flag |
| hardAddr | output | AW | Address of the latest hard error |
| softCount | output | SW | Saturating count of reads recovered by retry |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | AW | Memory address |
| memWdata | output | DW+2 | Stored word {addrPar, fullPar, data} |
| memRdata | input | DW+2 | Read word, one cycle after memEn |

## Verification
A wrong retry counter shows up as a read count other than the injected count plus one, and the ready pulse moves by the same number of cycles. A misclassified fault or a swapped parity bit appears as the wrong flag on the very response that carries the error. A lost address latch changes the address of the re-issued read. That corrupts the recomputed parity, so the response fails on the first access that needs a retry. A leaked write on a byte-parity error is visible as a memory write in that cycle and as changed data on the next read of the same address.

// File: rtl/dpsc_pkg.sv
package dpsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RESP  = 2'd2
  } dpscState_t;

  typedef struct packed {
    logic latch;
    logic memRead;
    logic memWrite;
    logic takeRead;
    logic takeHard;
    logic takeWrErr;
    logic bumpSoft;
  } dpscStb_t;

endpackage

// File: rtl/dpsc_ctrl.sv
module dpsc_ctrl
  import dpsc_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  localparam int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     byteErr,
  input  logic     chkErr,
  output dpscStb_t stb,
  output logic     reqReady
);

  dpscState_t state, stateNext;
  logic [RW-1:0] tries, triesNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    triesNext = tries;
    unique case (state)
      ST_IDLE: begin
        triesNext = '0;
        if (reqValid) begin
          stb.latch = 1'b1;
          if (reqWrite) begin
            if (byteErr) stb.takeWrErr = 1'b1;
            else         stb.memWrite  = 1'b1;
            stateNext = ST_RESP;
          end else begin
            stb.memRead = 1'b1;
            stateNext   = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (!chkErr) begin
          stb.takeRead = 1'b1;
          stb.bumpSoft = (tries != '0);
          stateNext    = ST_RESP;
        end else if (tries == RW'(MAX_RETRY)) begin
          stb.takeRead = 1'b1;
          stb.takeHard = 1'b1;
          stateNext    = ST_RESP;
        end else begin
          stb.memRead = 1'b1;
          triesNext   = tries + 1'b1;
        end
      end
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tries <= '0;
    end else begin
      state <= stateNext;
      tries <= triesNext;
    end
  end

  assign reqReady = (state == ST_RESP);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R8
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tries <= RW'(MAX_RETRY)); // R6
  AST_NO_ACCESS_IN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(stb.memRead || stb.memWrite)); // R8

endmodule

// File: rtl/dpsc_datapath.sv
module dpsc_datapath
  import dpsc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int SW = 8,
  localparam int NB = DW / 8,
  localparam int MW = DW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpscStb_t      stb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [NB-1:0] reqBytePar,
  output logic          byteErr,
  output logic          chkErr,
  output logic [DW-1:0] rspData,
  output logic          rspWrParErr,
  output logic          rspAddrFault,
  output logic          rspDataFault,
  output logic          rspHardErr,
  output logic          hardErr,
  output logic [AW-1:0] hardAddr,
  output logic [SW-1:0] softCount,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [MW-1:0] memWdata,
  input  logic [MW-1:0] memRdata
);

  logic [AW-1:0] addrQ;
  logic [NB-1:0] laneBad;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign laneBad[b] = ^{reqData[8*b +: 8], reqBytePar[b]};
  end
  assign byteErr = |laneBad;

  assign memEn    = stb.memRead | stb.memWrite;
  assign memWe    = stb.memWrite;
  assign memAddr  = stb.latch ? reqAddr : addrQ;
  assign memWdata = {^reqAddr, ^{reqAddr, reqData}, reqData};

  logic [DW-1:0] rdData;
  logic          addrBad, fullBad;
  assign rdData  = memRdata[DW-1:0];
  assign addrBad = memRdata[DW+1] ^ (^addrQ);
  assign fullBad = memRdata[DW] ^ (^{addrQ, rdData});
  assign chkErr  = addrBad | fullBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ        <= '0;
      rspData      <= '0;
      rspWrParErr  <= 1'b0;
      rspAddrFault <= 1'b0;
      rspDataFault <= 1'b0;
      rspHardErr   <= 1'b0;
      hardErr      <= 1'b0;
      hardAddr     <= '0;
      softCount    <= '0;
    end else begin
      if (stb.latch) begin
        addrQ        <= reqAddr;
        rspWrParErr  <= 1'b0;
        rspAddrFault <= 1'b0;
        rspDataFault <= 1'b0;
        rspHardErr   <= 1'b0;
      end
      if (stb.takeWrErr) rspWrParErr <= 1'b1;
      if (stb.takeRead)  rspData <= rdData;
      if (stb.takeHard) begin
        rspHardErr   <= 1'b1;
        rspAddrFault <= addrBad;
        rspDataFault <= !addrBad && fullBad;
        hardErr      <= 1'b1;
        hardAddr     <= addrQ;
      end
      if (stb.bumpSoft && softCount != {SW{1'b1}}) softCount <= softCount + 1'b1;
    end
  end

  AST_WRITE_NEEDS_CLEAN_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !byteErr); // R3
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rspAddrFault && rspDataFault)); // R4
  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hardErr |=> hardErr); // R6
  AST_SOFT_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    softCount >= $past(softCount)); // R7

endmodule

// File: rtl/dpsc_top.sv
module dpsc_top
  import dpsc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int MAX_RETRY = 3,
  localparam int NB = DW / 8,
  localparam int MW = DW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [NB-1:0] reqBytePar,
  output logic          reqReady,
  output logic [DW-1:0] rspData,
  output logic          rspWrParErr,
  output logic          rspAddrFault,
  output logic          rspDataFault,
  output logic          rspHardErr,
  output logic          hardErr,
  output logic [AW-1:0] hardAddr,
  output logic [SW-1:0] softCount,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [MW-1:0] memWdata,
  input  logic [MW-1:0] memRdata
);

  dpscStb_t stb;
  logic     byteErr, chkErr;

  dpsc_ctrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .byteErr(byteErr), .chkErr(chkErr), .stb(stb), .reqReady(reqReady)
  );

  dpsc_datapath #(.AW(AW), .DW(DW), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqData(reqData), .reqBytePar(reqBytePar),
    .byteErr(byteErr), .chkErr(chkErr),
    .rspData(rspData), .rspWrParErr(rspWrParErr),
    .rspAddrFault(rspAddrFault), .rspDataFault(rspDataFault),
    .rspHardErr(rspHardErr), .hardErr(hardErr), .hardAddr(hardAddr),
    .softCount(softCount), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: tb/sim_dpsc_top.sv
`timescale 1ns/1ps
module sim_dpsc_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SW = 8;
  localparam int NB = DW / 8;
  localparam int MW = DW + 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [NB-1:0] reqBytePar = '0;
  logic reqReady, rspWrParErr, rspAddrFault, rspDataFault, rspHardErr, hardErr;
  logic [DW-1:0] rspData;
  logic [AW-1:0] hardAddr, memAddr;
  logic [SW-1:0] softCount;
  logic memEn, memWe;
  logic [MW-1:0] memWdata, memRdata;

  always #2 clk = ~clk;

  dpsc_top #(.AW(AW), .DW(DW), .SW(SW), .MAX_RETRY(3)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqBytePar(reqBytePar),
    .reqReady(reqReady), .rspData(rspData), .rspWrParErr(rspWrParErr),
    .rspAddrFault(rspAddrFault), .rspDataFault(rspDataFault),
    .rspHardErr(rspHardErr), .hardErr(hardErr), .hardAddr(hardAddr),
    .softCount(softCount), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Memory model with read-side fault injection
  logic [MW-1:0] mem [DEPTH];
  int readTotal = 0, writeTotal = 0;
  int injBase = 0, injCount = 0;
  logic [MW-1:0] injMask = '0;

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        writeTotal <= writeTotal + 1;
      end else begin
        memRdata <= mem[memAddr] ^ (((readTotal - injBase) < injCount) ? injMask : '0);
        readTotal <= readTotal + 1;
      end
    end
  end

  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patData(input int a, input int salt);
    return DW'(a * 16'h1357 + salt * 16'h0F31 + 16'h02A1);
  endfunction

  function automatic logic [NB-1:0] goodPar(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  int cyc, nRd, nWr;
  logic cRdy;

  task automatic access(input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NB-1:0] p);
    int rb, wb;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d; reqBytePar = p;
    rb = readTotal; wb = writeTotal; injBase = readTotal; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!reqReady && cyc < 40);
    cRdy = reqReady;
    nRd = readTotal - rb;
    nWr = writeTotal - wb;
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R8", "ready pulse length", reqReady, 0);
  endtask

  logic [DW-1:0] golden [DEPTH];
  int expSoft = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk(!reqReady && !memEn && !hardErr, "R9", "ready/memEn/hardErr after reset",
        {reqReady, memEn, hardErr}, 0);
    chk(!rspWrParErr && !rspAddrFault && !rspDataFault && !rspHardErr, "R9",
        "flags after reset", {rspWrParErr, rspAddrFault, rspDataFault, rspHardErr}, 0);
    chk(softCount == 0, "R9", "softCount after reset", softCount, 0);
    rstN = 1'b1;

    // R1 R2: fill every address
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] d;
      logic [MW-1:0] expWord;
      d = patData(a, 0);
      golden[a] = d;
      access(1'b1, AW'(a), d, goodPar(d));
      expWord = {^AW'(a), ^{AW'(a), d}, d};
      chk(cRdy && cyc == 1, "R8", "write ready latency", cyc, 1);
      chk(nWr == 1 && nRd == 0, "R1", "write access count", nWr, 1);
      chk(mem[a] == expWord, "R2", "stored word layout", mem[a], expWord);
      chk(!rspWrParErr, "R1", "write flag", rspWrParErr, 0);
    end

    // Read sweep with injection kind x count
    for (int kind = 0; kind < 3; kind++) begin
      for (int k = 0; k <= 4; k++) begin
        for (int a = 0; a < DEPTH; a++) begin
          int expReads;
          bit expHard;
          injMask  = (kind == 0) ? MW'(1) << (DW + 1) :
                     (kind == 1) ? MW'(1) << (a % DW) : MW'(1) << DW;
          injCount = k;
          expReads = (k > 3 ? 3 : k) + 1;
          expHard  = (k >= 4);
          access(1'b0, AW'(a), '0, '0);
          injCount = 0;
          if (k >= 1 && k <= 3) expSoft++;
          chk(cRdy && cyc == expReads + 1, "R8", "read ready latency", cyc, expReads + 1);
          chk(nRd == expReads && nWr == 0, "R6", "read count", nRd, expReads);
          chk(rspHardErr == expHard, "R6", "rspHardErr", rspHardErr, expHard);
          if (!expHard) begin
            chk(rspData == golden[a], k == 0 ? "R1" : "R7", "read data", rspData, golden[a]);
            chk(!rspAddrFault && !rspDataFault, k == 0 ? "R1" : "R7", "clean flags",
                {rspAddrFault, rspDataFault}, 0);
          end else begin
            chk(hardErr && hardAddr == AW'(a), "R6", "hard flag/addr", hardAddr, a);
            if (kind == 0)
              chk(rspAddrFault && !rspDataFault, "R4", "address fault class",
                  {rspAddrFault, rspDataFault}, 2'b10);
            else
              chk(!rspAddrFault && rspDataFault, "R5", "data fault class",
                  {rspAddrFault, rspDataFault}, 2'b01);
          end
          chk(softCount == SW'(expSoft), "R7", "softCount", softCount, expSoft);
        end
      end
    end

    // R3: byte parity errors on writes, every address and lane
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < NB; b++) begin
        logic [DW-1:0] d;
        d = patData(a, b + 1);
        access(1'b1, AW'(a), d, goodPar(d) ^ NB'(1 << b));
        chk(cRdy && cyc == 1, "R3", "rejected write latency", cyc, 1);
        chk(rspWrParErr, "R3", "rspWrParErr", rspWrParErr, 1);
        chk(nWr == 0 && nRd == 0, "R3", "no memory access", nWr + nRd, 0);
        access(1'b0, AW'(a), '0, '0);
        chk(rspData == golden[a] && !rspWrParErr, "R3", "old data kept", rspData, golden[a]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule